// File: doc/BRIEF.md
# Interrupt Request and Sleep Wake Controller

This block collects three interrupt causes for a small 8-bit core: a one-cycle overflow pulse from the on-chip timer, an edge on the external interrupt pin, and a mismatch on an 8-bit input port. Each cause sets its own pending flag. The flag stays set until software clears it. The flags are combined with per-source enable bits and a global enable to form one interrupt request. When the core takes the request, it jumps to a fixed vector address.

The same flags can bring the core out of its low-power sleep. Only the pin source and the port-mismatch source can do this, because the timer is halted during sleep. Wake is raised for an enabled pin or port flag even while the global enable is clear. In that case the core resumes after its sleep instruction without vectoring. The interrupt pin shares its package pin with bit 0 of the port, so a level change there can set both the pin flag and the port flag.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. The timer and the register-file decode that produce the strobes live outside this block.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset, `flag_o` is 3'b000, `gie_o` is 0, `irq_o` is 0 and `wake_o` is 0. The port snapshot resets to 8'h00.
- R2: A high `tmr_ovf_i` at a clock edge sets `flag_o[0]` (the timer flag) at that edge.
- R3: `pin_i` passes through two synchronizing flops before edge detection. `edge_rise_i`=1 selects the rising edge and 0 selects the falling edge. A matching transition sets `flag_o[1]` on the third clock edge after the change. The opposite transition has no effect.
- R4: A high `port_rd_i` at a clock edge copies `port_i` into the snapshot. At every edge where `port_i` differs from the snapshot in any bit, `flag_o[2]` is set. A `port_i` equal to the snapshot sets nothing.
- R5: Each flag holds until its `clr_i` bit is high at an edge. A set event at the same edge as the clear wins, so the flag stays 1. Clearing one bit leaves the other flags unchanged.
- R6: `irq_o` is 1 exactly when `gie_o` is 1 and some bit of `flag_o & en_i` is 1. Bit order is 0 timer, 1 pin, 2 port.
- R7: `irq_take_i` clears `gie_o` at the next edge and overrides `gie_set_i`. Otherwise `gie_set_i` sets `gie_o`, and `gie_clr_i` clears it.
- R8: `wake_o` is 1 exactly when `sleep_i` is 1 and `flag_o[1]&en_i[1]` or `flag_o[2]&en_i[2]` is 1. This holds whatever `gie_o` is. The timer flag never raises `wake_o`.
- R9: `vec_o` always carries the hardware interrupt vector 10'h008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_ovf_i | input | 1 | One-cycle timer overflow pulse |
| pin_i | input | 1 | Asynchronous external interrupt pin level |
| edge_rise_i | input | 1 | 1 selects the rising pin edge, 0 the falling edge |
| port_i | input | 8 | Synchronized input port value |
| port_rd_i | input | 1 | Port read strobe; refreshes the snapshot |
| en_i | input | 3 | Per-source enables (0 timer, 1 pin, 2 port) |
| clr_i | input | 3 | Per-flag clear strobes |
| gie_set_i | input | 1 | Set the global enable (return from interrupt) |
| gie_clr_i | input | 1 | Clear the global enable by software |
| irq_take_i | input | 1 | Core accepts the interrupt |
| sleep_i | input | 1 | Core is in sleep |
| flag_o | output | 3 | Pending flags |
| gie_o | output | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request to the core |
| vec_o | output | 10 | Hardware interrupt vector address |

## Verification
A wrong synchronizer or edge-select state shows as `flag_o[1]` rising one edge early or late, or not rising at all, at the third edge after a pin transition. A stale port snapshot shows as `flag_o[2]` setting while the port is unchanged, or staying quiet after a bit flips, on the very next edge. A wrong global-enable state shows at once on `irq_o` across the enable sweep. A bad flag-to-wake gating shows as `wake_o` following the timer flag or depending on `gie_o`.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  localparam int unsigned NSRC = 3;

  typedef enum logic [1:0] {
    SRC_TMR  = 2'd0,
    SRC_PIN  = 2'd1,
    SRC_PORT = 2'd2
  } src_e;

  typedef logic [NSRC-1:0] src_vec_t;

  // mask of the sources that may raise wake while the core sleeps
  localparam src_vec_t WAKE_MASK = src_vec_t'(3'b110);
endpackage

// File: rtl/iw_pin_edge.sv
module iw_pin_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  // sr[0..STAGES-1] are the synchronizer, sr[STAGES] is the previous level
  logic [STAGES:0] sr;

  for (genvar g = 0; g <= STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sr[g] <= 1'b0;
        else        sr[g] <= pin_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) sr[g] <= 1'b0;
        else        sr[g] <= sr[g-1];
      end
    end
  end

  logic lvl, prev;
  assign lvl  = sr[STAGES-1];
  assign prev = sr[STAGES];

  always_comb begin
    if (rise_sel_i) edge_o = lvl & ~prev;
    else            edge_o = ~lvl & prev;
  end
endmodule

// File: rtl/iw_port_change.sv
module iw_port_change #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] port_i,
  input  logic         rd_i,
  output logic         chg_o
);
  logic [W-1:0] snap;
  logic [W-1:0] diff;

  always_ff @(posedge clk) begin
    if (!rst_n)    snap <= '0;
    else if (rd_i) snap <= port_i;
  end

  assign diff  = port_i ^ snap;
  assign chg_o = |diff;
endmodule

// File: rtl/iw_flags.sv
module iw_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flag_o[k] <= 1'b0;
      else if (set_i[k]) flag_o[k] <= 1'b1;   // event beats clear
      else if (clr_i[k]) flag_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/iw_gie.sv
module iw_gie (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic set_i,
  input  logic clr_i,
  output logic gie_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      gie_o <= 1'b0;
    else if (take_i) gie_o <= 1'b0;
    else if (set_i)  gie_o <= 1'b1;
    else if (clr_i)  gie_o <= 1'b0;
  end
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_wake_pkg::*;
#(
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned SYNC_N   = 2,
  parameter int unsigned PC_W     = 10,
  parameter logic [PC_W-1:0] VEC_ADDR = 10'h008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_ovf_i,
  input  logic              pin_i,
  input  logic              edge_rise_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              port_rd_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic [NSRC-1:0]   clr_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  input  logic              irq_take_i,
  input  logic              sleep_i,
  output logic [NSRC-1:0]   flag_o,
  output logic              gie_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic [PC_W-1:0]   vec_o
);
  logic     pin_edge, port_chg;
  src_vec_t set_vec, live;

  iw_pin_edge #(.STAGES(SYNC_N)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .rise_sel_i(edge_rise_i), .edge_o(pin_edge)
  );

  iw_port_change #(.W(PORT_W)) u_port (
    .clk(clk), .rst_n(rst_n), .port_i(port_i),
    .rd_i(port_rd_i), .chg_o(port_chg)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_TMR]  = tmr_ovf_i;
    set_vec[SRC_PIN]  = pin_edge;
    set_vec[SRC_PORT] = port_chg;
  end

  iw_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec),
    .clr_i(clr_i), .flag_o(flag_o)
  );

  iw_gie u_gie (
    .clk(clk), .rst_n(rst_n), .take_i(irq_take_i),
    .set_i(gie_set_i), .clr_i(gie_clr_i), .gie_o(gie_o)
  );

  assign live   = flag_o & en_i;
  assign irq_o  = gie_o & (|live);
  assign wake_o = sleep_i & (|(live & WAKE_MASK));
  assign vec_o  = VEC_ADDR;
endmodule

// File: rtl/irq_wake_ctrl_chk.sv
module irq_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_ovf_i,
  input logic [2:0] clr_i,
  input logic       irq_take_i,
  input logic       sleep_i,
  input logic [2:0] flag_o,
  input logic       gie_o,
  input logic       irq_o,
  input logic       wake_o
);
  // R2
  tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_i |=> flag_o[0]);
  // R2
  tmr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o[0]) |-> $past(tmr_ovf_i));
  // R5
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o[1] && !clr_i[1]) |=> flag_o[1]);
  // R5
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o[2] && !clr_i[2]) |=> flag_o[2]);
  // R6
  irq_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_o);
  // R7
  take_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_i |=> !gie_o);
  // R8
  wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> sleep_i);
  // R8
  wake_tmr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o == 3'b001) |-> !wake_o);
endmodule

bind irq_wake_ctrl irq_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_ovf_i(tmr_ovf_i), .clr_i(clr_i),
  .irq_take_i(irq_take_i), .sleep_i(sleep_i), .flag_o(flag_o),
  .gie_o(gie_o), .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/test_irq_wake_ctrl.sv
`timescale 1ns/1ps
module test_irq_wake_ctrl;
  logic clk = 0, rst_n = 0;
  logic tmr = 0, pin = 0, rise = 1, prd = 0, gset = 0, gclr = 0, take = 0, slp = 0;
  logic [7:0] port = 0;
  logic [2:0] en = 0, clr = 0;
  logic [2:0] flag;
  logic gie, irq, wake;
  logic [9:0] vec;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_wake_ctrl i_irq_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .tmr_ovf_i(tmr), .pin_i(pin), .edge_rise_i(rise),
    .port_i(port), .port_rd_i(prd), .en_i(en), .clr_i(clr),
    .gie_set_i(gset), .gie_clr_i(gclr), .irq_take_i(take), .sleep_i(slp),
    .flag_o(flag), .gie_o(gie), .irq_o(irq), .wake_o(wake), .vec_o(vec)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pin_edge_set;  // toggle pin with the matching edge selected
    rise = ~pin; pin = ~pin; step(3);
  endtask

  task automatic clear_all;
    prd = 1; step(1); prd = 0;
    clr = 3'b111; step(1); clr = 0;
  endtask

  initial begin
    step(3); rst_n = 1; step(1);
    // R1 reset state
    check("R1 flag", flag, 0); check("R1 gie", gie, 0);
    check("R1 irq", irq, 0);   check("R1 wake", wake, 0);
    // R9 vector
    check("R9 vec", vec, 10'h008);

    // R2 timer pulse
    tmr = 1; step(1); tmr = 0;
    check("R2 tmr flag", flag, 3'b001);
    // R5 clear with simultaneous event keeps flag
    tmr = 1; clr = 3'b001; step(1); tmr = 0; clr = 0;
    check("R5 set wins", flag, 3'b001);
    clr = 3'b001; step(1); clr = 0;
    check("R5 cleared", flag, 3'b000);

    // R3 pin edge sweep: each edge select x each transition
    for (int s = 0; s < 2; s++) begin
      for (int t = 0; t < 2; t++) begin
        rise = s[0]; clr = 3'b010; step(1); clr = 0;
        pin = ~pin;
        step(2);
        check("R3 not early", flag[1], 0);
        step(1);
        // rising transition if pin now 1
        check("R3 edge", flag[1], (pin == rise));
      end
    end
    clr = 3'b010; step(1); clr = 0;

    // R4 port change sweep over every bit
    prd = 1; step(1); prd = 0;
    step(1);
    check("R4 no change", flag[2], 0);
    for (int b = 0; b < 8; b++) begin
      port = port ^ (8'h1 << b);
      step(1);
      check("R4 bit flip", flag[2], 1);
      prd = 1; step(1); prd = 0;
      clr = 3'b100; step(1); clr = 0;
      step(1);
      check("R4 resynced", flag[2], 0);
    end
    // R5 clear of one bit leaves others
    tmr = 1; step(1); tmr = 0;
    port = port ^ 8'h80; step(1);
    prd = 1; step(1); prd = 0;
    clr = 3'b001; step(1); clr = 0;
    check("R5 selective", flag, 3'b100);
    clear_all();

    // R7 global enable
    gset = 1; step(1); gset = 0; check("R7 set", gie, 1);
    take = 1; gset = 1; step(1); take = 0; gset = 0; check("R7 take wins", gie, 0);
    gset = 1; step(1); gset = 0;
    gclr = 1; step(1); gclr = 0; check("R7 clr", gie, 0);

    // R6/R8 sweep: flag masks x enables x gie x sleep
    for (int m = 0; m < 8; m++) begin
      clear_all();
      if (m[0]) begin tmr = 1; step(1); tmr = 0; end
      if (m[1]) pin_edge_set();
      if (m[2]) begin
        port = port ^ 8'h01; step(1);
        prd = 1; step(1); prd = 0;
      end
      check("R5 mask", flag, m[2:0]);
      for (int e = 0; e < 8; e++) begin
        for (int g = 0; g < 2; g++) begin
          for (int sl = 0; sl < 2; sl++) begin
            logic [2:0] lv;
            en = e[2:0];
            slp = sl[0];
            if (g == 1) gset = 1; else gclr = 1;
            step(1); gset = 0; gclr = 0;
            lv = m[2:0] & e[2:0];
            check("R6 irq", irq, (g == 1) && (lv != 0));
            check("R8 wake", wake, (sl == 1) && (lv[1] || lv[2]));
          end
        end
      end
      en = 0; slp = 0;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule